// File: doc/BRIEF.md
# Priority Chain Dataway Arbiter

This block decides when one of several crate controllers sharing a single dataway may run a cycle. The controllers form a priority chain. The head of the chain wires its own request output back to its grant input. Every other controller takes its grant input from the grant output of the controller just above it. Each instance raises its request once its local cycle controller asks for a cycle. It then waits for the grant and gives the cycle controller a one-clock permission pulse. It keeps the request raised until the cycle controller reports the end of the cycle. While it is not requesting, the grant it receives flows straight on to the next controller down the chain.

Two static settings shape the behaviour. An online/offline control keeps a parked controller from ever requesting the dataway. A head/auxiliary setting decides what an offline controller does with the grant. An auxiliary controller stays transparent. A head controller that is taken offline quiesces every controller below it. The grant input arrives from another board, so it passes through a flip-flop synchronizer before the state machine uses it. The synchronizer depth is a parameter, with a default of two.

Top module: `chain_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `req_o`, `go_o` and `owner_o` are all low.
- R2: While `req_o` is low and the instance is online, `grant_out_o` equals `grant_in_i` in the same cycle, with no clock delay.
- R3: A high `start_i` sampled at a clock edge while online and idle makes `req_o` high after that edge.
- R4: While `req_o` is high, `grant_out_o` is low, whatever the value of `grant_in_i`.
- R5: The instance may be pending with a request and `grant_in_i` high. `go_o` then pulses high for exactly one cycle, SYNC_STAGES+1 clock edges after the first edge that samples `grant_in_i` high. With the default of 2, that is the third edge. `go_o` never rises unless a request was pending.
- R6: After the grant is taken, `owner_o` and `req_o` stay high until an edge samples `cycle_done_i` high. Both are low right after that edge.
- R7: A `start_i` that arrives while a request is pending or a cycle is owned is ignored. It produces no further `go_o` pulse, and `req_o` falls at the normal end of the current cycle.
- R8: While `online_i` is low (offline), `start_i` is ignored and `req_o` stays low.
- R9: A pending request that has not yet been granted is discarded when the instance goes offline. `req_o` falls after the next edge. A grant that arrives later, even after the instance is back online, produces no `go_o`.
- R10: While offline, `grant_out_o` depends on the mode. With `main_mode_i` high (chain head) it is held low. With `main_mode_i` low (auxiliary) it follows `grant_in_i`.
- R11: A cycle that is already owned when the instance goes offline runs to completion. `req_o` and `owner_o` stay high until `cycle_done_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| online_i | input | 1 | 1 = online, may request; 0 = offline |
| main_mode_i | input | 1 | 1 = chain head, 0 = auxiliary controller |
| start_i | input | 1 | Local cycle controller asks for a dataway cycle |
| cycle_done_i | input | 1 | Local cycle controller reports its cycle finished |
| grant_in_i | input | 1 | Grant from the controller above, or own request looped back at the head |
| req_o | output | 1 | Request for the dataway |
| grant_out_o | output | 1 | Grant passed to the controller below |
| go_o | output | 1 | One-clock permission to start the dataway cycle |
| owner_o | output | 1 | This instance holds the dataway |

## Verification
Suppose the state machine wrongly returns to idle, or never leaves the pending state. The fault shows within one clock as a `req_o` that falls early or never falls, and as a `grant_out_o` that no longer blocks the chain. A fault in the synchronizer depth or in the pending condition moves the `go_o` pulse off the expected edge, so the bench compares the edge on which each pulse arrives, not only its presence. Stale starts, and grants that arrive after an offline discard, must produce no pulse at all, and any pulse that was not expected is reported at once.

// File: rtl/chain_arbiter_pkg.sv
// Shared types for the priority chain arbiter.
// Assumes: nothing beyond a standard SystemVerilog compiler.
package chain_arbiter_pkg;

    // Ownership phases of one chain member.
    typedef enum logic [1:0] {
        ARB_IDLE = 2'd0,
        ARB_WAIT = 2'd1,
        ARB_OWN  = 2'd2
    } arb_state_t;

endpackage

// File: rtl/chain_arbiter_sync.sv
// Multi-flop synchronizer for the asynchronous grant input.
// Assumes: STAGES >= 2; the input is a level that stays stable for several clocks.
module chain_arbiter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain; clears on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/chain_arbiter_fsm.sv
// Ownership state machine: takes a local start, waits for the synchronized
// grant, pulses go, holds ownership until the cycle ends.
// Assumes: cycle_done_i is only raised by the local cycle controller while owning.
module chain_arbiter_fsm
    import chain_arbiter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic online_i,
    input  logic start_i,
    input  logic cycle_done_i,
    input  logic grant_sync_i,
    output logic req_o,
    output logic go_o,
    output logic owner_o
);

    arb_state_t state_q;
    arb_state_t state_d;
    logic       go_d;
    logic       go_q;

    // Next-state decode for the ownership phases.
    always_comb begin
        state_d = state_q;
        go_d    = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                if (online_i && start_i) begin
                    state_d = ARB_WAIT;
                end
            end
            ARB_WAIT: begin
                if (!online_i) begin
                    state_d = ARB_IDLE;
                end else if (grant_sync_i) begin
                    state_d = ARB_OWN;
                    go_d    = 1'b1;
                end
            end
            ARB_OWN: begin
                if (cycle_done_i) begin
                    state_d = ARB_IDLE;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // State and go-pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            go_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            go_q    <= go_d;
        end
    end

    assign req_o   = (state_q != ARB_IDLE);
    assign owner_o = (state_q == ARB_OWN);
    assign go_o    = go_q;

endmodule

// File: rtl/chain_arbiter_pass.sv
// Grant forwarding toward lower-priority controllers.
// Assumes: req_i is a registered signal, so the output glitches only with grant_in_i.
module chain_arbiter_pass (
    input  logic online_i,
    input  logic main_mode_i,
    input  logic req_i,
    input  logic grant_in_i,
    output logic grant_out_o
);

    logic quiesce;

    // An offline chain head starves everything below it.
    assign quiesce = main_mode_i && !online_i;

    // Forward the raw grant unless this member is requesting or quiescing.
    always_comb begin
        if (quiesce || req_i) begin
            grant_out_o = 1'b0;
        end else begin
            grant_out_o = grant_in_i;
        end
    end

endmodule

// File: rtl/chain_arbiter.sv
// Top of one priority chain member: synchronizer, ownership FSM, grant pass.
// Assumes: the head member loops req_o to grant_in_i externally; others take
// grant_in_i from the member above.
module chain_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic online_i,
    input  logic main_mode_i,
    input  logic start_i,
    input  logic cycle_done_i,
    input  logic grant_in_i,
    output logic req_o,
    output logic grant_out_o,
    output logic go_o,
    output logic owner_o
);

    logic grant_sync;

    chain_arbiter_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(grant_in_i),
        .sync_o (grant_sync)
    );

    chain_arbiter_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .online_i    (online_i),
        .start_i     (start_i),
        .cycle_done_i(cycle_done_i),
        .grant_sync_i(grant_sync),
        .req_o       (req_o),
        .go_o        (go_o),
        .owner_o     (owner_o)
    );

    chain_arbiter_pass u_pass (
        .online_i   (online_i),
        .main_mode_i(main_mode_i),
        .req_i      (req_o),
        .grant_in_i (grant_in_i),
        .grant_out_o(grant_out_o)
    );

endmodule

// File: rtl/chain_arbiter_chk.sv
// Property checker for chain_arbiter, attached with bind below.
// Assumes: sampled on the same clock and reset as the arbiter.
module chain_arbiter_chk #(
    parameter int SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic online_i,
    input logic main_mode_i,
    input logic start_i,
    input logic cycle_done_i,
    input logic grant_in_i,
    input logic req_o,
    input logic grant_out_o,
    input logic go_o,
    input logic owner_o
);

    AST_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        req_o |-> !grant_out_o); // R4

    AST_GO_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |=> !go_o); // R5

    AST_GO_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(req_o)); // R5

    AST_GO_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        go_o |-> $past(grant_in_i, SYNC_STAGES + 1)); // R5

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_o && !cycle_done_i) |=> (req_o && owner_o)); // R6

    AST_DROP_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_o && cycle_done_i) |=> !req_o); // R6

    AST_OFFLINE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (!online_i && !owner_o) |=> !req_o); // R8

    AST_HEAD_QUIESCE: assert property (@(posedge clk) disable iff (!rst_n)
        (main_mode_i && !online_i) |-> !grant_out_o); // R10

    AST_OWNED_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (owner_o && !online_i && !cycle_done_i) |=> owner_o); // R11

endmodule

bind chain_arbiter chain_arbiter_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (.*);

// File: tb/chain_arbiter_tb.sv
// Scoreboard bench: driver tasks queue the cycle number where each go pulse
// is due; a monitor pops and compares every pulse the arbiter produces.
module chain_arbiter_tb;

    logic clk = 1'b0;
    logic rst_n, online, main_mode, start, done, gi_drv, loop_en;
    logic grant_in, req, grant_out, go, owner;
    int   cyc = 0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   exp_q[$];
    bit   finished = 1'b0;

    always #10 clk = ~clk;

    assign grant_in = loop_en ? req : gi_drv;

    chain_arbiter u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .online_i    (online),
        .main_mode_i (main_mode),
        .start_i     (start),
        .cycle_done_i(done),
        .grant_in_i  (grant_in),
        .req_o       (req),
        .grant_out_o (grant_out),
        .go_o        (go),
        .owner_o     (owner)
    );

    // Cycle stamp used by the scoreboard.
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string rq, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Pulse start for one clock; optionally queue the cycle where go is due.
    task automatic do_start(input int due_in);
        start = 1'b1;
        if (due_in > 0) exp_q.push_back(cyc + due_in);
        step(1);
        start = 1'b0;
    endtask

    task automatic finish_cycle(input string rq);
        done = 1'b1;
        step(1);
        done = 1'b0;
        check(req == 1'b0, rq, req, 0);
        check(owner == 1'b0, rq, owner, 0);
    endtask

    // Monitor: every go pulse must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && go) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R9 unexpected go", cyc, -1);
            end else begin
                int due;
                due = exp_q.pop_front();
                check(due == cyc, "R5 go cycle", cyc, due);
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", cyc, 5000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; online = 1'b1; main_mode = 1'b0; start = 1'b0;
        done = 1'b0; gi_drv = 1'b0; loop_en = 1'b0;
        step(3);
        check(req == 1'b0, "R1 req in reset", req, 0);
        check(go == 1'b0, "R1 go in reset", go, 0);
        check(owner == 1'b0, "R1 owner in reset", owner, 0);
        rst_n = 1'b1;
        step(1);
        check(req == 1'b0, "R1 req after reset", req, 0);

        // R2: idle pass-through, same cycle.
        gi_drv = 1'b1; #1;
        check(grant_out == 1'b1, "R2 pass high", grant_out, 1);
        gi_drv = 1'b0; #1;
        check(grant_out == 1'b0, "R2 pass low", grant_out, 0);

        // Explicit grant from above (auxiliary member).
        step(1);
        do_start(0);
        check(req == 1'b1, "R3 request raised", req, 1);
        exp_q.push_back(cyc + 3);
        gi_drv = 1'b1; #1;
        check(grant_out == 1'b0, "R4 grant blocked", grant_out, 0);
        step(4);
        check(owner == 1'b1, "R6 owner taken", owner, 1);
        check(go == 1'b0, "R5 go one cycle", go, 0);
        do_start(0);                       // R7: ignored while owning
        step(3);
        check(req == 1'b1, "R6 request held", req, 1);
        finish_cycle("R6 release on done");
        check(grant_out == 1'b1, "R2 pass after release", grant_out, 1);
        gi_drv = 1'b0;
        step(4);

        // R7: start during wait is ignored; one go only.
        do_start(0);
        do_start(0);
        exp_q.push_back(cyc + 3);
        gi_drv = 1'b1;
        step(6);
        finish_cycle("R7 single cycle");
        gi_drv = 1'b0;
        step(4);

        // Chain head with request looped to grant.
        main_mode = 1'b1; loop_en = 1'b1;
        do_start(4);
        step(5);
        check(owner == 1'b1, "R5 head owns via loop", owner, 1);
        finish_cycle("R6 head release");
        step(4);

        // R8: offline ignores start.
        online = 1'b0;
        do_start(0);
        step(3);
        check(req == 1'b0, "R8 no request offline", req, 0);

        // R10: offline grant forwarding by mode.
        loop_en = 1'b0; gi_drv = 1'b1; #1;
        check(grant_out == 1'b0, "R10 head quiesces", grant_out, 0);
        main_mode = 1'b0; #1;
        check(grant_out == 1'b1, "R10 aux transparent", grant_out, 1);
        gi_drv = 1'b0;
        online = 1'b1;
        step(4);

        // R9: going offline discards a pending request.
        do_start(0);
        check(req == 1'b1, "R9 pending", req, 1);
        online = 1'b0;
        step(1);
        check(req == 1'b0, "R9 discarded", req, 0);
        online = 1'b1; gi_drv = 1'b1;
        step(5);
        check(owner == 1'b0, "R9 late grant ignored", owner, 0);
        check(req == 1'b0, "R9 stays idle", req, 0);
        gi_drv = 1'b0;
        step(4);

        // R11: offline while owning lets the cycle finish.
        do_start(0);
        exp_q.push_back(cyc + 3);
        gi_drv = 1'b1;
        step(4);
        online = 1'b0;
        step(2);
        check(req == 1'b1, "R11 request kept", req, 1);
        check(owner == 1'b1, "R11 owner kept", owner, 1);
        finish_cycle("R11 release");
        online = 1'b1; gi_drv = 1'b0;
        step(4);

        check(exp_q.size() == 0, "R5 missing go", exp_q.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule